// File: doc/BRIEF.md
# Mixed-Access Control and Status Register Bank

This block is a compact set of 32-bit registers that software reaches over a plain synchronous bus. The bus has one address, a write strobe with write data, and a read strobe. Read data comes back from a register one cycle after the read strobe. Every register has one fixed access behaviour:

- plain read/write,
- read-only mirror of a hardware level,
- write-only trigger,
- read-to-clear capture,
- write-one-to-clear status.

Bits outside a register's defined width read back as zero, and writes to them are discarded.

Hardware pulses set bits in two event registers. One holds latched status and is cleared by writing ones. The other holds captured pulses and empties when it is read. A pair of write-only strobe registers sets or clears single control bits. Software therefore never needs a read-modify-write sequence, which could lose an update.

A protected configuration register takes a write only when the bus write just before it placed the unlock key in the key register. An interrupt output is raised whenever a latched status bit is set and its enable bit is also set.

The bus is a plain strobe interface with no flow control. Every access completes in the cycle it is presented, so no back-pressure applies. At most one address is presented per cycle. If a read and a write are both asserted, they target the same register, and the read returns the contents from before the write.

Register indices on `bus_addr`:

| Index | Register |
|-------|----------|
| 0 | control |
| 1 | control-set |
| 2 | control-clear |
| 3 | status |
| 4 | capture |
| 5 | interrupt enable |
| 6 | level mirror |
| 7 | key |
| 8 | protected configuration |

Top module: `csr_bank`

## Requirements
- R1: After reset, every register, `bus_rd_data`, `ctrl_out`, `prot_out` and `irq` are zero.
- R2: The control register (index 0) is read/write. Only bits [15:0] are stored; bits [31:16] read as zero whatever was written.
- R3: A write to control-set (index 1) sets each control bit written as 1. A write to control-clear (index 2) clears each control bit written as 1. Other control bits keep their value. Indices 1, 2 and the key register (index 7) always read as zero.
- R4: Status (index 3, bits [7:0]) is write-one-to-clear. A pulse on `evt_set[i]` sets bit i. A written 1 clears the bit, and a written 0 leaves it unchanged. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Capture (index 4, bits [7:0]) is read-clear. A pulse on `capt_set[i]` sets bit i. A performed read returns the value and then empties the register, except for bits set in that same cycle. Writes to it and cycles without a read leave it unchanged.
- R6: The level mirror (index 6, bits [15:0]) is read-only. It returns `hw_level` as sampled in the read cycle, and writes to it change nothing.
- R7: The protected register (index 8, bits [15:0], mirrored on `prot_out`) accepts a write only if the most recent earlier bus write was the value 0xC0DE5A5A to index 7. Cycles without a write do not count as writes. Any bus write consumes the unlock, whether or not that write was accepted.
- R8: `irq` is high exactly when some status bit and the matching interrupt-enable bit (index 5, read/write, bits [7:0]) are both 1.
- R9: `bus_rd_data` holds the value read in the cycle after `bus_rd_en` and is zero after a cycle without a read. Unmapped indices 9 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register index for read and write |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| evt_set | input | 8 | Hardware pulses setting status bits |
| capt_set | input | 8 | Hardware pulses setting capture bits |
| hw_level | input | 16 | Hardware level shown by the read-only register |
| ctrl_out | output | 16 | Current control register value |
| prot_out | output | 16 | Current protected register value |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobes, address and hardware pulse inputs are known (never X) in every cycle after reset. They also assume that one address serves both a read and a write presented together. The unlock properties further assume that a write strobe marks every bus write, so that an idle cycle between the key write and the protected write is legal and keeps the unlock. The stimulus drives all inputs on the falling clock edge from fixed values after reset. It mixes idle cycles, combined read-write cycles, correct and wrong keys, and hardware pulses that coincide with clears, so each of these assumptions is exercised without being violated.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int unsigned IX_CTRL = 0;
  localparam int unsigned IX_CSET = 1;
  localparam int unsigned IX_CCLR = 2;
  localparam int unsigned IX_STAT = 3;
  localparam int unsigned IX_CAPT = 4;
  localparam int unsigned IX_IEN  = 5;
  localparam int unsigned IX_LVL  = 6;
  localparam int unsigned IX_KEY  = 7;
  localparam int unsigned IX_PROT = 8;
  localparam int unsigned NREG    = 9;

  typedef logic [NREG-1:0] reg_hit_t;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  localparam int unsigned SPAN = 1 << ADDR_W;

  initial begin
    if (SPAN < NREG) $error("address width too small for register count");
  end

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(i));
  end

  // one index selects at most one register
  always_comb begin
    assert ($onehot0(hit) || $isunknown(addr));
  end
endmodule

// File: rtl/csr_key_gate.sv
module csr_key_gate #(
  parameter int unsigned     DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY  = 32'hC0DE_5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              key_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              armed
);
  // Armed only by the most recent write; any other write disarms.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (wr_en) armed <= key_sel && (wr_data == KEY);
  end

  AST_ARM_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && key_sel && (wr_data == KEY))); // R7

  AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && !key_sel) |=> !armed); // R7
endmodule

// File: rtl/csr_event_bits.sv
module csr_event_bits #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_strobe,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_vec;

  assign clr_vec = clr_strobe ? clr_mask : '0;

  // set applied after clear: a same-cycle hardware event survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_vec) | set_i;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q & $past(set_i)) == $past(set_i))); // R4

  AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_strobe) |=> ((q & $past(q)) == $past(q))); // R5
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       ADDR_W     = 4,
  parameter int unsigned       CTRL_W     = 16,
  parameter int unsigned       STAT_W     = 8,
  parameter int unsigned       CAPT_W     = 8,
  parameter int unsigned       LVL_W      = 16,
  parameter int unsigned       PROT_W     = 16,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hC0DE_5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic [STAT_W-1:0] evt_set,
  input  logic [CAPT_W-1:0] capt_set,
  input  logic [LVL_W-1:0]  hw_level,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [PROT_W-1:0] prot_out,
  output logic              irq
);
  localparam int unsigned MAXF = (CTRL_W > LVL_W) ? CTRL_W : LVL_W;

  initial begin
    if (MAXF > DATA_W || PROT_W > DATA_W || STAT_W > DATA_W || CAPT_W > DATA_W)
      $error("field wider than data bus");
  end

  reg_hit_t           hit;
  logic               armed;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [STAT_W-1:0]  ien_q;
  logic [PROT_W-1:0]  prot_q;
  logic [STAT_W-1:0]  stat_q;
  logic [CAPT_W-1:0]  capt_q;
  logic [DATA_W-1:0]  rd_mux;
  logic               wr_ctrl, wr_cset, wr_cclr, wr_ien, wr_prot, wr_stat, rd_capt;

  csr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  csr_key_gate #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en),
    .key_sel (hit[IX_KEY]),
    .wr_data (bus_wr_data),
    .armed   (armed)
  );

  assign wr_ctrl = bus_wr_en && hit[IX_CTRL];
  assign wr_cset = bus_wr_en && hit[IX_CSET];
  assign wr_cclr = bus_wr_en && hit[IX_CCLR];
  assign wr_ien  = bus_wr_en && hit[IX_IEN];
  assign wr_stat = bus_wr_en && hit[IX_STAT];
  assign wr_prot = bus_wr_en && hit[IX_PROT] && armed;
  assign rd_capt = bus_rd_en && hit[IX_CAPT];

  // write-one-to-clear status
  csr_event_bits #(.W(STAT_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_set),
    .clr_strobe (wr_stat),
    .clr_mask   (bus_wr_data[STAT_W-1:0]),
    .q          (stat_q)
  );

  // read-clear capture
  csr_event_bits #(.W(CAPT_W)) u_capt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (capt_set),
    .clr_strobe (rd_capt),
    .clr_mask   ({CAPT_W{1'b1}}),
    .q          (capt_q)
  );

  // control: direct write, or bit set / bit clear strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wr_data[CTRL_W-1:0];
    else if (wr_cset) ctrl_q <= ctrl_q | bus_wr_data[CTRL_W-1:0];
    else if (wr_cclr) ctrl_q <= ctrl_q & ~bus_wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wr_data[STAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prot_q <= '0;
    else if (wr_prot) prot_q <= bus_wr_data[PROT_W-1:0];
  end

  // read mux; write-only and unmapped indices return zero
  always_comb begin
    rd_mux = '0;
    if (hit[IX_CTRL]) rd_mux = DATA_W'(ctrl_q);
    if (hit[IX_STAT]) rd_mux = DATA_W'(stat_q);
    if (hit[IX_CAPT]) rd_mux = DATA_W'(capt_q);
    if (hit[IX_IEN])  rd_mux = DATA_W'(ien_q);
    if (hit[IX_LVL])  rd_mux = DATA_W'(hw_level);
    if (hit[IX_PROT]) rd_mux = DATA_W'(prot_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rd_data <= '0;
    else if (bus_rd_en) bus_rd_data <= rd_mux;
    else                bus_rd_data <= '0;
  end

  assign ctrl_out = ctrl_q;
  assign prot_out = prot_q;
  assign irq      = |(stat_q & ien_q);

  AST_PROT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && hit[IX_PROT] && armed) |=> $stable(prot_out)); // R7

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> (bus_rd_data == '0)); // R9

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && hit[IX_CTRL]) |=> (bus_rd_data[DATA_W-1:CTRL_W] == '0)); // R2

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && (hit[IX_CSET] || hit[IX_CCLR] || hit[IX_KEY])) |=> (bus_rd_data == '0)); // R3

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq); // R8

  AST_RC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_capt && capt_set == '0) |=> (capt_q == '0)); // R5

  AST_LVL_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && hit[IX_LVL]) |=> (bus_rd_data == DATA_W'($past(hw_level)))); // R6
endmodule

// File: tb/csr_bank_test.sv
`timescale 1ns/1ps
module csr_bank_test;
  localparam logic [31:0] KEY = 32'hC0DE_5A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  evt = '0;
  logic [7:0]  capt = '0;
  logic [15:0] lvl = '0;
  logic [15:0] ctrl_out, prot_out;
  logic        irq;

  always #4 clk = ~clk;

  csr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en),
    .bus_wr_data(wdata), .bus_rd_en(rd_en), .bus_rd_data(rd_data),
    .evt_set(evt), .capt_set(capt), .hw_level(lvl),
    .ctrl_out(ctrl_out), .prot_out(prot_out), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_ctrl, m_prot;
  logic [7:0]  m_stat, m_capt, m_ien;
  bit          m_arm;
  logic [31:0] m_rd;
  string       m_tag;

  function automatic logic [31:0] mread(input logic [3:0] a);
    case (a)
      4'd0: return {16'h0, m_ctrl};
      4'd3: return {24'h0, m_stat};
      4'd4: return {24'h0, m_capt};
      4'd5: return {24'h0, m_ien};
      4'd6: return {16'h0, lvl};
      4'd8: return {16'h0, m_prot};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagof(input logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1, 4'd2, 4'd7: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R8";
      4'd6: return "R6";
      4'd8: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_prot = '0; m_stat = '0; m_capt = '0; m_ien = '0;
      m_arm = 0; m_rd = '0; m_tag = "R1";
    end else begin
      m_rd  = rd_en ? mread(addr) : 32'h0;
      m_tag = rd_en ? tagof(addr) : "R9";
      if (wr_en) begin
        case (addr)
          4'd0: m_ctrl = wdata[15:0];
          4'd1: m_ctrl = m_ctrl | wdata[15:0];
          4'd2: m_ctrl = m_ctrl & ~wdata[15:0];
          4'd3: m_stat = m_stat & ~wdata[7:0];
          4'd5: m_ien  = wdata[7:0];
          4'd8: if (m_arm) m_prot = wdata[15:0];
          default: ;
        endcase
        m_arm = (addr == 4'd7) && (wdata == KEY);
      end
      if (rd_en && addr == 4'd4) m_capt = '0;
      m_stat = m_stat | evt;
      m_capt = m_capt | capt;
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(m_tag, rd_data, m_rd);
      chk("R8", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
      chk("R2/R3", {16'h0, ctrl_out}, {16'h0, m_ctrl});
      chk("R7", {16'h0, prot_out}, {16'h0, m_prot});
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    evt = '0; capt = '0; rd_en = 0; wr_en = 1; addr = a; wdata = d;
  endtask

  task automatic bus_wr_evt(input logic [3:0] a, input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    capt = '0; rd_en = 0; wr_en = 1; addr = a; wdata = d; evt = e;
  endtask

  task automatic bus_idle();
    @(negedge clk);
    evt = '0; capt = '0; rd_en = 0; wr_en = 0;
  endtask

  task automatic pulse(input logic [7:0] e, input logic [7:0] c);
    @(negedge clk);
    rd_en = 0; wr_en = 0; evt = e; capt = c;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    evt = '0; capt = '0; wr_en = 0; rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", rd_data, 32'h0);
    chk("R1", {31'h0, irq}, 32'h0);
    chk("R1", {16'h0, ctrl_out}, 32'h0);
    chk("R1", {16'h0, prot_out}, 32'h0);
    bus_rd(4'd3, d); chk("R1", d, 32'h0);

    // R2 reserved bits
    bus_wr(4'd0, 32'hFFFF_FFFF);
    bus_rd(4'd0, d); chk("R2", d, 32'h0000_FFFF);

    // R3 set / clear strobes
    bus_wr(4'd2, 32'h0000_FF00);
    bus_wr(4'd1, 32'h0000_1200);
    bus_rd(4'd0, d); chk("R3", d, 32'h0000_12FF);
    bus_rd(4'd1, d); chk("R3", d, 32'h0);
    bus_rd(4'd7, d); chk("R3", d, 32'h0);

    // R4 write-one-to-clear, set wins
    pulse(8'h04, 8'h00);
    bus_rd(4'd3, d); chk("R4", d, 32'h04);
    bus_wr(4'd3, 32'h0);
    bus_rd(4'd3, d); chk("R4", d, 32'h04);
    bus_wr_evt(4'd3, 32'h04, 8'h04);
    bus_rd(4'd3, d); chk("R4", d, 32'h04);
    bus_wr(4'd3, 32'h04);
    bus_rd(4'd3, d); chk("R4", d, 32'h0);

    // R8 interrupt
    bus_wr(4'd5, 32'h08);
    pulse(8'h08, 8'h00);
    bus_idle();
    chk("R8", {31'h0, irq}, 32'h1);
    bus_wr(4'd3, 32'h08);
    bus_idle();
    chk("R8", {31'h0, irq}, 32'h0);

    // R5 read-clear
    pulse(8'h00, 8'h02);
    bus_rd(4'd4, d); chk("R5", d, 32'h02);
    bus_rd(4'd4, d); chk("R5", d, 32'h0);
    pulse(8'h00, 8'h10);
    bus_wr(4'd4, 32'hFF);
    bus_idle();
    bus_rd(4'd4, d); chk("R5", d, 32'h10);

    // R6 read-only mirror
    lvl = 16'h00AB;
    bus_wr(4'd6, 32'hFFFF_FFFF);
    bus_rd(4'd6, d); chk("R6", d, 32'h00AB);

    // R7 key-protected register
    bus_wr(4'd7, KEY);
    bus_wr(4'd8, 32'h1234);
    bus_rd(4'd8, d); chk("R7", d, 32'h1234);
    bus_wr(4'd8, 32'h5555);
    bus_rd(4'd8, d); chk("R7", d, 32'h1234);
    bus_wr(4'd7, KEY);
    bus_idle();
    bus_wr(4'd8, 32'h7777);
    bus_rd(4'd8, d); chk("R7", d, 32'h7777);
    bus_wr(4'd7, KEY);
    bus_wr(4'd0, 32'h1);
    bus_wr(4'd8, 32'h9999);
    bus_rd(4'd8, d); chk("R7", d, 32'h7777);
    bus_wr(4'd7, KEY ^ 32'h1);
    bus_wr(4'd8, 32'hAAAA);
    bus_rd(4'd8, d); chk("R7", d, 32'h7777);

    // R9 unmapped
    bus_rd(4'd15, d); chk("R9", d, 32'h0);
    bus_rd(4'd9, d);  chk("R9", d, 32'h0);

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      begin
        int op;
        logic [3:0] a;
        op = $urandom % 4;
        a  = 4'($urandom % 11);
        wr_en = (op == 1) || (op == 3);
        rd_en = (op == 2) || (op == 3);
        addr  = a;
        wdata = (a == 4'd7 && ($urandom % 2) == 0) ? KEY : $urandom;
        evt   = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
        capt  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
        lvl   = 16'($urandom);
      end
    end
    bus_idle();
    bus_idle();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule